// File: doc/BRIEF.md
# Four-Port Mailbox Interrupt Controller

This block produces message-passing interrupts for four synchronous ports that share one memory. Each port owns one reserved address near the top of the address space, its mailbox. When any other port writes that address, the owner's interrupt line goes low. The line stays low until the owner reads its own mailbox. The memory array and the data path sit outside this block. The block only watches each port's address, write strobe and enables, and drives one active-low interrupt per port.

All ports run on one shared clock. An access counts only on a rising edge where that port is enabled. Each flag is a register that is updated on the edge that registers the access. The interrupt output therefore moves one cycle after the access is presented. An asynchronous active-low reset returns every interrupt line high, independent of the clock.

Top module: `mbx_irq`

## Requirements
- R1: While rst_ni is low, every bit of int_no_o is 1, and this takes effect without a clock edge.
- R2: An enabled write by port p to the mailbox of port q, with q different from p, drives int_no_o[q] to 0 after the next rising edge.
- R3: An enabled write by a port to its own mailbox address leaves its own int_no_o bit unchanged.
- R4: An enabled read (wr_i bit = 0) by port q of its own mailbox returns int_no_o[q] to 1 after the next rising edge, unless the same edge also sets that flag.
- R5: A read of a mailbox address by a port that does not own it leaves every int_no_o bit unchanged.
- R6: A port is enabled only when its ce0_ni bit is 0 and its ce1_i bit is 1. A port that is not enabled neither sets nor clears any flag.
- R7: If a set and a clear of the same flag fall on the same rising edge, the flag ends up set (int_no_o bit = 0).
- R8: Writes and reads to addresses that are not mailboxes do not change any int_no_o bit.
- R9: The mailbox of port index q (0 to 3) is the all-ones address minus q, that is 0xFFFF, 0xFFFE, 0xFFFD and 0xFFFC for a 16-bit address.
- R10: With no set or clear for a flag on an edge, its int_no_o bit holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared clock of all ports |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4x16 | Per-port address, element p for port p |
| wr_i | input | 4 | Per-port direction, 1 = write, 0 = read |
| ce0_ni | input | 4 | Per-port active-low enable |
| ce1_i | input | 4 | Per-port active-high enable |
| int_no_o | output | 4 | Per-port active-low interrupt |

## Verification
The sweep drives every port against every mailbox address and some neighbouring addresses, in both directions and under all four enable combinations. It catches two faults. A decoder that swaps two mailbox addresses shows up as the wrong line going low. A block that ignores one of the two enables would set flags that should have stayed quiet. Targeted cases cover a port writing its own mailbox, a read by a port that does not own the mailbox, and a set and clear of the same flag on the same edge. If the own-write were not blocked, the port would interrupt itself. If the priority were wrong, a message arriving in the same edge as the owner's read would be lost. A reset applied between clock edges checks that the lines rise without waiting for the clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int NP = 4,
  parameter int AW = 16,
  parameter int P  = 0
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          ce0_ni,
  input  logic          ce1_i,
  output logic [NP-1:0] set_o,   // request to set flag q
  output logic          clr_o    // read of own mailbox
);
  localparam logic [AW-1:0] TOP_ADDR = '1;

  acc_e acc;

  always_comb begin
    if (ce0_ni || !ce1_i) acc = ACC_NONE;
    else if (wr_i)        acc = ACC_WR;
    else                  acc = ACC_RD;
  end

  for (genvar q = 0; q < NP; q++) begin : g_tgt
    if (q == P) begin : g_self
      assign set_o[q] = 1'b0;
    end else begin : g_other
      assign set_o[q] = (acc == ACC_WR) && (addr_i == TOP_ADDR - AW'(q));
    end
  end

  assign clr_o = (acc == ACC_RD) && (addr_i == TOP_ADDR - AW'(P));
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic int_no_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;   // set beats clear
    else if (clr_i) flag_q <= 1'b0;
  end

  assign int_no_o = ~flag_q;
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int NP = 4,
  parameter int AW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NP-1:0][AW-1:0]  addr_i,
  input  logic [NP-1:0]          wr_i,
  input  logic [NP-1:0]          ce0_ni,
  input  logic [NP-1:0]          ce1_i,
  output logic [NP-1:0]          int_no_o
);
  logic [NP-1:0][NP-1:0] set_req;  // [src][dst]
  logic [NP-1:0]         clr_req;
  logic [NP-1:0]         set_any;

  for (genvar p = 0; p < NP; p++) begin : g_port
    mbx_port_dec #(.NP(NP), .AW(AW), .P(p)) u_dec (
      .addr_i (addr_i[p]),
      .wr_i   (wr_i[p]),
      .ce0_ni (ce0_ni[p]),
      .ce1_i  (ce1_i[p]),
      .set_o  (set_req[p]),
      .clr_o  (clr_req[p])
    );
  end

  always_comb begin
    set_any = '0;
    for (int s = 0; s < NP; s++) set_any |= set_req[s];
  end

  for (genvar q = 0; q < NP; q++) begin : g_flag
    mbx_flag u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_any[q]),
      .clr_i    (clr_req[q]),
      .int_no_o (int_no_o[q])
    );
  end
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int NP = 4,
  parameter int AW = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NP-1:0][AW-1:0] addr_i,
  input logic [NP-1:0]         wr_i,
  input logic [NP-1:0]         ce0_ni,
  input logic [NP-1:0]         ce1_i,
  input logic [NP-1:0]         int_no_o
);
  logic [NP-1:0] en, hit_set, hit_clr;

  always_comb begin
    en = ~ce0_ni & ce1_i;
    hit_set = '0;
    hit_clr = '0;
    for (int q = 0; q < NP; q++) begin
      for (int p = 0; p < NP; p++) begin
        if (p != q && en[p] && wr_i[p] && (addr_i[p] == ({AW{1'b1}} - AW'(q))))
          hit_set[q] = 1'b1;
      end
      if (en[q] && !wr_i[q] && (addr_i[q] == ({AW{1'b1}} - AW'(q))))
        hit_clr[q] = 1'b1;
    end
  end

  // R1
  reset_high_chk: assert property (@(posedge clk_i) !rst_ni |-> (&int_no_o));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |=> $stable(int_no_o));

  for (genvar q = 0; q < NP; q++) begin : g_q
    // R2
    set_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_set[q] |=> !int_no_o[q]);
    // R4
    clr_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_clr[q] && !hit_set[q]) |=> int_no_o[q]);
    // R10
    hold_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit_clr[q] && !hit_set[q]) |=> $stable(int_no_o[q]));
  end
endmodule

bind mbx_irq mbx_irq_chk #(.NP(NP), .AW(AW)) u_chk (.*);

// File: tb/sim_mbx_irq.sv
module sim_mbx_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 16;

  logic                  clk_i = 1'b0;
  logic                  rst_ni;
  logic [NP-1:0][AW-1:0] addr_i;
  logic [NP-1:0]         wr_i;
  logic [NP-1:0]         ce0_ni;
  logic [NP-1:0]         ce1_i;
  logic [NP-1:0]         int_no_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [NP-1:0] mflag;

  mbx_irq #(.NP(NP), .AW(AW)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [AW-1:0] mbx(input int q);
    return 16'hFFFF - 16'(q);
  endfunction

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: int_no=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce0_ni = '1; ce1_i = '0; wr_i = '0; addr_i = '0;
  endtask

  task automatic drv(input int p, input logic [AW-1:0] a, input logic w,
                     input logic c0n, input logic c1);
    addr_i[p] = a; wr_i[p] = w; ce0_ni[p] = c0n; ce1_i[p] = c1;
  endtask

  // model from requirement rules R2..R9
  task automatic step(input string tag);
    logic [NP-1:0] s, c;
    s = '0; c = '0;
    for (int q = 0; q < NP; q++) begin
      for (int p = 0; p < NP; p++)
        if (p != q && !ce0_ni[p] && ce1_i[p] && wr_i[p] && addr_i[p] == mbx(q)) s[q] = 1'b1;
      if (!ce0_ni[q] && ce1_i[q] && !wr_i[q] && addr_i[q] == mbx(q)) c[q] = 1'b1;
    end
    mflag = s | (mflag & ~c);
    @(posedge clk_i); #1;
    chk(tag, int_no_o, ~mflag);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: int_no=%b expected completion", int_no_o);
    finish_run();
  end

  initial begin
    idle();
    mflag = '0;
    rst_ni = 1'b0;
    #2;
    chk("R1 reset", int_no_o, 4'b1111);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R2 / R9: port 0 writes 0xFFFE -> port 1 line low
    drv(0, 16'hFFFE, 1'b1, 1'b0, 1'b1); step("R2 R9 p0->p1");
    chk("R2 literal", int_no_o, 4'b1101);
    // R3: port 2 writes own 0xFFFD -> no change
    drv(2, 16'hFFFD, 1'b1, 1'b0, 1'b1); step("R3 own write");
    chk("R3 literal", int_no_o, 4'b1101);
    // R5: port 0 reads 0xFFFE -> no clear
    drv(0, 16'hFFFE, 1'b0, 1'b0, 1'b1); step("R5 foreign read");
    chk("R5 literal", int_no_o, 4'b1101);
    // R6: disabled write by port 3 to 0xFFFF
    drv(3, 16'hFFFF, 1'b1, 1'b1, 1'b1); step("R6 ce0 off");
    drv(3, 16'hFFFF, 1'b1, 1'b0, 1'b0); step("R6 ce1 off");
    chk("R6 literal", int_no_o, 4'b1101);
    // R8: non-mailbox write
    drv(3, 16'hFFFB, 1'b1, 1'b0, 1'b1); step("R8 plain write");
    // R10: idle holds
    step("R10 hold");
    chk("R10 literal", int_no_o, 4'b1101);
    // R4: port 1 reads 0xFFFE
    drv(1, 16'hFFFE, 1'b0, 1'b0, 1'b1); step("R4 owner read");
    chk("R4 literal", int_no_o, 4'b1111);
    // R7: port 3 writes 0xFFFE while port 1 reads it
    drv(3, 16'hFFFE, 1'b1, 1'b0, 1'b1);
    drv(1, 16'hFFFE, 1'b0, 1'b0, 1'b1); step("R7 set wins");
    chk("R7 literal", int_no_o, 4'b1101);
    // R9: port 1 sets port 3 via 0xFFFC and port 0 via 0xFFFF
    drv(1, 16'hFFFC, 1'b1, 1'b0, 1'b1); step("R9 p1->p3");
    drv(2, 16'hFFFF, 1'b1, 1'b0, 1'b1); step("R9 p2->p0");
    chk("R9 literal", int_no_o, 4'b0100);

    // sweep: every port, addresses 0xFFF8..0xFFFF, both directions, all enables
    for (int p = 0; p < NP; p++)
      for (int a = 8; a < 16; a++)
        for (int w = 0; w < 2; w++)
          for (int e = 0; e < 4; e++) begin
            drv(p, 16'hFFF0 + 16'(a), w[0], e[0], e[1]);
            step("R2 R3 R4 R5 R6 R8 R9 sweep");
          end

    // concurrent random traffic on all ports
    for (int i = 0; i < 400; i++) begin
      for (int p = 0; p < NP; p++)
        drv(p, 16'hFFFA + 16'($urandom_range(0, 5)), 1'($urandom), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 3) != 0));
      step("R7 R10 multi-port");
    end

    // R1: asynchronous reset between edges
    drv(0, 16'hFFFD, 1'b1, 1'b0, 1'b1); step("R2 pre-reset");
    @(negedge clk_i);
    rst_ni = 1'b0; #1;
    chk("R1 async", int_no_o, 4'b1111);
    mflag = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step("R1 after reset");

    finish_run();
  end
endmodule